// File: doc/BRIEF.md
# Post-Update Indexed Store Unit

This unit carries out one integer store with post-update addressing on a 64-bit datapath. A decoded request supplies the base register number and its value, an index value, the source data, a two-bit shift field, a size code and a scale-enable flag. The unit writes to memory at the base value as it was before the request. It computes a new effective address from the base and the index, scaled or unscaled. When the memory write completes, it returns that new address as a write-back to the base register.

The memory side is a valid/ready request. It carries a 64-bit address, an 8-bit byte-enable mask and lane-aligned write data in little-endian lane order. The unit handles one request at a time. A request that names register 0 as its base is rejected: the unit raises an illegal flag and makes neither the memory write nor the write-back. Each request, completed or rejected, gives one single-cycle done pulse.

Top module: `pu_store_unit`

## Requirements
- R1: With `req_scale_en`=1, the new address is `req_base_val + (req_index_val << (req_shamt+1))` modulo 2^64, so the shift is 1 to 4. It appears on `wb_data`.
- R2: With `req_scale_en`=0, the new address is `req_base_val + req_index_val` modulo 2^64, and `req_shamt` has no effect.
- R3: `mem_addr` equals the `req_base_val` of the accepted request, not the new address.
- R4: `req_size` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. The low bytes of `req_src_val` are placed in `mem_wdata` starting at byte lane `mem_addr[2:0]`, where lane k is bits 8k+7..8k. All other lanes are zero, and bytes that would fall past lane 7 are dropped.
- R5: `mem_be` bit k is 1 exactly for the lanes that R4 fills with data.
- R6: A request accepted with `req_base_idx`=0 gives `illegal`=1 and `done`=1 for one cycle, in the cycle after acceptance. No `mem_valid` and no `wb_valid` are produced.
- R7: `mem_valid` rises in the cycle after a valid request with a non-zero base index is accepted. `mem_addr`, `mem_be` and `mem_wdata` then hold steady until `mem_ready` is seen.
- R8: `wb_valid`, carrying `wb_idx` = the base index and `wb_data` = the new address, is high only in the cycle where `mem_valid` and `mem_ready` are both high. `done` is high in that same cycle, and `mem_valid` is low in the next cycle.
- R9: `req_ready` is high only while idle. A request offered while a store is in flight is not taken.
- R10: After reset, `req_ready`=1 and `mem_valid`, `wb_valid`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request taken on this edge |
| req_base_idx | input | 5 | Base register number |
| req_base_val | input | 64 | Base register value |
| req_index_val | input | 64 | Index register value |
| req_src_val | input | 64 | Source data |
| req_shamt | input | 2 | Shift field, scaled shift is this plus one |
| req_size | input | 2 | Access size code |
| req_scale_en | input | 1 | 1 = scaled index, 0 = plain sum |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write address (old base) |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-aligned write data |
| wb_valid | output | 1 | Base register write-back pulse |
| wb_idx | output | 5 | Write-back register number |
| wb_data | output | 64 | Write-back value (new address) |
| illegal | output | 1 | Rejected request pulse |
| done | output | 1 | Request finished pulse |

## Verification
The memory request fields are registered, so they are due one clock after the accepting edge. The bench samples them at the following falling edge and samples them again at every falling edge of an induced stall. The write-back, `done` and the handshake share one combinational cycle: the bench raises `mem_ready` at a falling edge and checks `wb_valid`, `wb_data` and `done` one nanosecond later, before the next rising edge. For a rejected request, `illegal` and `done` are due one clock after acceptance and are gone one clock later. The bench checks both edges of that pulse.

// File: rtl/pu_store_pkg.sv
// Package: shared types for the post-update store unit.
// Assumes a 64-bit datapath with eight byte lanes.
package pu_store_pkg;
    // Access size codes; bytes = 1 << code.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    // Control states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_REJECT = 2'd2
    } state_e;
endpackage

// File: rtl/pu_ea_gen.sv
// Module: effective-address adder. Adds base and index, with the index
// optionally shifted left by (shamt + 1). Purely combinational; the sum
// wraps modulo 2^XLEN.
module pu_ea_gen #(
    parameter int XLEN = 64,
    parameter int SH_W = 2
) (
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    input  logic [SH_W-1:0] shamt,
    input  logic            scale_en,
    output logic [XLEN-1:0] ea
);
    localparam int AMT_W = SH_W + 1;

    logic [AMT_W-1:0] amt;
    logic [XLEN-1:0]  scaled;

    // Shift distance is the field plus one, only when scaling is on.
    always_comb begin
        amt    = {1'b0, shamt} + AMT_W'(1);
        scaled = scale_en ? (index_val << amt) : index_val;
        ea     = base_val + scaled;
    end
endmodule

// File: rtl/pu_lane_pack.sv
// Module: lane formatter. Builds the byte-enable mask and places the low
// bytes of the source into lanes starting at the address offset
// (little-endian lane order). Bytes pushed past the top lane are dropped.
module pu_lane_pack #(
    parameter int XLEN = 64
) (
    input  logic [1:0]                  size,
    input  logic [$clog2(XLEN/8)-1:0]   offset,
    input  logic [XLEN-1:0]             src,
    output logic [XLEN/8-1:0]           be,
    output logic [XLEN-1:0]             wdata
);
    localparam int LANES = XLEN / 8;

    logic [LANES-1:0] nmask;
    logic [XLEN-1:0]  dmask;

    // Lanes covered by the access before alignment.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            nmask[i] = (i < (1 << size));
        end
    end

    // Expand the lane mask to a bit mask.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dmask[8*g +: 8] = {8{nmask[g]}};
    end

    // Shift mask and masked data up to the offset lane.
    always_comb begin
        be    = nmask << offset;
        wdata = (src & dmask) << {offset, 3'b000};
    end
endmodule

// File: rtl/pu_store_ctrl.sv
// Module: request sequencer. Idle accepts one request; a zero base index
// goes to a one-cycle reject state, otherwise the memory request is held
// until ready. Synchronous active-low reset.
module pu_store_ctrl
    import pu_store_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic base_zero,
    input  logic mem_ready,
    output logic req_ready,
    output logic load,
    output logic mem_valid,
    output logic wb_fire,
    output logic illegal,
    output logic done
);
    state_e state_q;
    logic   take;

    // Decode outputs from the current state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        take      = req_valid && req_ready;
        load      = take && !base_zero;
        mem_valid = (state_q == ST_SEND);
        wb_fire   = mem_valid && mem_ready;
        illegal   = (state_q == ST_REJECT);
        done      = wb_fire || illegal;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (take) state_q <= base_zero ? ST_REJECT : ST_SEND;
                ST_SEND:   if (mem_ready) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pu_store_unit.sv
// Module: post-update indexed store unit (top). Writes at the old base
// address, computes base + scaled index, and returns that sum to the base
// register as the memory handshake completes. Assumes the requester holds
// the request fields while req_valid is high.
module pu_store_unit #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int SH_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_base_idx,
    input  logic [XLEN-1:0]   req_base_val,
    input  logic [XLEN-1:0]   req_index_val,
    input  logic [XLEN-1:0]   req_src_val,
    input  logic [SH_W-1:0]   req_shamt,
    input  logic [1:0]        req_size,
    input  logic              req_scale_en,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              illegal,
    output logic              done
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [XLEN-1:0]  ea_d;
    logic [LANES-1:0] be_d;
    logic [XLEN-1:0]  wdata_d;
    logic             load;
    logic             base_zero;

    logic [XLEN-1:0]  addr_q, ea_q, wdata_q;
    logic [LANES-1:0] be_q;
    logic [IDX_W-1:0] idx_q;

    assign base_zero = (req_base_idx == '0);

    pu_ea_gen #(.XLEN(XLEN), .SH_W(SH_W)) u_ea (
        .base_val  (req_base_val),
        .index_val (req_index_val),
        .shamt     (req_shamt),
        .scale_en  (req_scale_en),
        .ea        (ea_d)
    );

    pu_lane_pack #(.XLEN(XLEN)) u_pack (
        .size   (req_size),
        .offset (req_base_val[OFF_W-1:0]),
        .src    (req_src_val),
        .be     (be_d),
        .wdata  (wdata_d)
    );

    pu_store_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .base_zero (base_zero),
        .mem_ready (mem_ready),
        .req_ready (req_ready),
        .load      (load),
        .mem_valid (mem_valid),
        .wb_fire   (wb_valid),
        .illegal   (illegal),
        .done      (done)
    );

    // Capture the formatted request on acceptance; hold until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            ea_q    <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            idx_q   <= '0;
        end else if (load) begin
            addr_q  <= req_base_val;
            ea_q    <= ea_d;
            wdata_q <= wdata_d;
            be_q    <= be_d;
            idx_q   <= req_base_idx;
        end
    end

    // Drive the memory and write-back fields from the held request.
    always_comb begin
        mem_addr  = addr_q;
        mem_be    = be_q;
        mem_wdata = wdata_q;
        wb_idx    = idx_q;
        wb_data   = ea_q;
    end
endmodule

// File: rtl/pu_store_chk.sv
// Module: assertion checker for pu_store_unit, attached by bind below.
module pu_store_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int SH_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IDX_W-1:0]  req_base_idx,
    input logic [XLEN-1:0]   req_base_val,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN/8-1:0] mem_be,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              illegal,
    input logic              done
);
    // R3: the write goes to the base value that was accepted.
    p_addr_old_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_base_idx != '0) |=> (mem_addr == $past(req_base_val)));

    // R5: a live request always enables at least one lane.
    p_be_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be != '0));

    // R6: a zero base index is rejected on the next cycle.
    p_zero_idx_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_base_idx == '0) |=> (illegal && done && !mem_valid));

    // R6: a rejection never coincides with any write.
    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_valid && !wb_valid));

    // R7: a valid request with a non-zero base leads to a memory request.
    p_mem_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_base_idx != '0) |=> mem_valid);

    // R7: a stalled request holds every field.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_be) && $stable(mem_wdata)));

    // R8: the write-back only comes with the memory handshake, to a real register.
    p_wb_on_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (mem_valid && mem_ready && done && wb_idx != '0));

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the unit takes nothing while a store is in flight.
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !illegal));
endmodule

bind pu_store_unit pu_store_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .SH_W(SH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_base_idx (req_base_idx),
    .req_base_val (req_base_val),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .illegal      (illegal),
    .done         (done)
);

// File: tb/pu_store_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for pu_store_unit: one task per scenario.
module pu_store_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_base_idx = '0;
    logic [63:0] req_base_val = '0;
    logic [63:0] req_index_val = '0;
    logic [63:0] req_src_val = '0;
    logic [1:0]  req_shamt = '0;
    logic [1:0]  req_size = '0;
    logic        req_scale_en = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        illegal;
    logic        done;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pu_store_unit u_pu_store_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base_idx(req_base_idx), .req_base_val(req_base_val),
        .req_index_val(req_index_val), .req_src_val(req_src_val),
        .req_shamt(req_shamt), .req_size(req_size), .req_scale_en(req_scale_en),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .illegal(illegal), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One store with the expected results worked out byte by byte.
    task automatic run_store(input logic [4:0] idx, input logic [63:0] base, input logic [63:0] index,
                             input logic [63:0] src, input logic [1:0] sh, input logic [1:0] size,
                             input logic scale, input int stall, input string ea_tag);
        logic [63:0] exp_ea, exp_data;
        logic [7:0]  exp_be;
        int off, nb;
        off = int'(base[2:0]);
        nb  = 1 << size;
        exp_ea = scale ? base + (index << (int'(sh) + 1)) : base + index;
        exp_be = '0;
        exp_data = '0;
        for (int k = 0; k < 8; k++) begin
            if (k >= off && k < off + nb) begin
                exp_be[k] = 1'b1;
                exp_data[8*k +: 8] = src[8*(k-off) +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_base_idx = idx; req_base_val = base; req_index_val = index;
        req_src_val = src; req_shamt = sh; req_size = size; req_scale_en = scale;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_valid == 1'b1, "R7 mem_valid after accept", 64'(mem_valid), 64'd1);
        chk(mem_addr == base, "R3 mem_addr is old base", mem_addr, base);
        chk(mem_be == exp_be, "R5 byte enables", 64'(mem_be), 64'(exp_be));
        chk(mem_wdata == exp_data, "R4 lane data", mem_wdata, exp_data);
        if (stall > 0) begin
            // Offer a competing request while busy; it must not be taken.
            req_valid = 1'b1; req_base_idx = 5'd9; req_base_val = ~base;
        end
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R9 not ready while busy", 64'(req_ready), 64'd0);
            chk(mem_valid && mem_addr == base && mem_be == exp_be && mem_wdata == exp_data,
                "R7 held during stall", mem_addr, base);
            chk(!wb_valid && !done, "R8 no write-back before ready", 64'(wb_valid), 64'd0);
        end
        req_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        chk(wb_valid == 1'b1 && done == 1'b1, "R8 wb_valid and done on handshake", 64'({wb_valid, done}), 64'd3);
        chk(wb_idx == idx, "R8 wb_idx", 64'(wb_idx), 64'(idx));
        chk(wb_data == exp_ea, ea_tag, wb_data, exp_ea);
        @(negedge clk);
        mem_ready = 1'b0;
        chk(!mem_valid && !wb_valid && !done && req_ready, "R8 returns idle after handshake",
            64'({mem_valid, wb_valid, done, req_ready}), 64'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready && !mem_valid && !wb_valid && !done && !illegal, "R10 reset state",
            64'({req_ready, mem_valid, wb_valid, done, illegal}), 64'h10);
    endtask

    task automatic t_scaled();
        for (int sh = 0; sh < 4; sh++)
            run_store(5'd3, 64'h1000, 64'h10, 64'h11, 2'(sh), 2'd0, 1'b1, 0, "R1 scaled address");
        run_store(5'd31, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 64'hAB, 2'd0, 2'd0, 1'b1, 0, "R1 wrap around");
    endtask

    task automatic t_unscaled();
        run_store(5'd4, 64'h2000, 64'h18, 64'h55, 2'd3, 2'd3, 1'b0, 0, "R2 plain sum");
        run_store(5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1, 2'd1, 2'd0, 1'b0, 0, "R2 plain sum wrap");
    endtask

    task automatic t_sizes();
        for (int sz = 0; sz < 4; sz++)
            for (int o = 0; o < 8; o += 3)
                run_store(5'd7, 64'h4000 + 64'(o), 64'h8, 64'h8877_6655_4433_2211, 2'd1, 2'(sz), 1'b1, 0,
                          "R4 size/offset address");
    endtask

    task automatic t_stall();
        run_store(5'd12, 64'h8004, 64'h3, 64'hDEAD_BEEF_CAFE_F00D, 2'd2, 2'd2, 1'b1, 3, "R7 stalled store address");
    endtask

    task automatic t_illegal();
        @(negedge clk);
        req_valid = 1'b1; req_base_idx = 5'd0; req_base_val = 64'h100; req_size = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        chk(illegal && done, "R6 illegal and done", 64'({illegal, done}), 64'd3);
        chk(!mem_valid && !wb_valid, "R6 no write", 64'({mem_valid, wb_valid}), 64'd0);
        @(negedge clk);
        mem_ready = 1'b0;
        chk(!illegal && !done && req_ready && !mem_valid, "R6 pulse ends",
            64'({illegal, done, req_ready, mem_valid}), 64'd2);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scaled();
        t_unscaled();
        t_sizes();
        t_stall();
        t_illegal();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule